// File: doc/BRIEF.md
# Network Loop-Code Detector with Automatic Remote Loopback

This block watches a recovered receive bit stream, one bit for each cycle of a bit enable, for two repeating in-band codes. The loop-up code repeats the 5-bit pattern 00001 and the loop-down code repeats the 3-bit pattern 001. A code counts as held once it has been present, without interruption, for more bit times than a persistence parameter. That parameter is nominally five seconds at the line rate. A bench can shrink it to a few bits.

A 2-bit mode input picks one of four behaviours. In the first, detection is off. In two manual modes the status bit simply follows one chosen code. In the automatic mode a held loop-up code latches a remote-loopback enable. That enable holds until a held loop-down code arrives or the mode changes. Every change of the status bit can raise a one-clock interrupt pulse. The datapath that performs the loopback, the line interface and any register access lie outside the block.

Top module: `loop_code_detector`

## Requirements
- R1: With mode 2'b00 the status bit and the remote-loopback enable stay 0 whatever bits arrive. Both are 0 after reset.
- R2: In mode 2'b01 the status bit becomes 1 once the loop-up code (bits 0,0,0,0,1 in arrival order, repeating) is held. It returns to 0 on the first accepted bit that breaks the pattern.
- R3: In mode 2'b10 the status bit follows the loop-down code (bits 0,0,1, repeating) in the same way. A loop-up stream does not set it.
- R4: A window matches when the last L accepted bits (L = code length) form any rotation of the code. Each accepted bit with a matching window adds one to a run count. Any accepted bit without a match, and any mode change, clears that count. A code is held when the run count exceeds PERSIST_BITS. The status bit changes on the clock after the bit enable that completes the run.
- R5: When irq_en was 1 at the clock where the status bit takes a new value, rising or falling, the interrupt output is 1 for exactly that one clock. When irq_en was 0 there is no pulse.
- R6: Entering automatic mode (mode 2'b11 with an allowed test code) clears the status bit and restarts persistence. A loop-up code already running must be held afresh for more than PERSIST_BITS bits.
- R7: In automatic mode a held loop-up code sets both the status bit and the remote-loopback enable. Both stay 1 after the loop-up code stops.
- R8: In automatic mode with loopback active, a held loop-down code clears both the remote-loopback enable and the status bit.
- R9: Leaving automatic mode clears the remote-loopback enable on the next clock.
- R10: With tx_test equal to 3'b110, mode 2'b11 behaves as detection off: status and loopback stay 0.
- R11: While local_analog_lb is 1, a held loop-up code in automatic mode does not set the remote-loopback enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Qualifies rx_bit as one received bit time |
| rx_bit | input | 1 | Recovered receive data bit |
| mode | input | 2 | 00 off, 01 manual loop-up, 10 manual loop-down, 11 automatic |
| tx_test | input | 3 | Transmit-test code; 3'b110 blocks automatic mode |
| local_analog_lb | input | 1 | Local analog loopback is active |
| irq_en | input | 1 | Enables the interrupt pulse |
| code_status | output | 1 | Detect status bit |
| remote_lb_en | output | 1 | Remote loopback enable |
| irq | output | 1 | One-clock interrupt pulse on a status change |

## Verification
The persistence count is a small number in the bench, and a run of ones before every code makes the first matching window fall at a known bit. That lets the bench probe one bit before and exactly at the threshold. Each code is sent in the mode that selects it and in the mode that does not, which separates a loop-up match from a loop-down match. A single broken bit shows that a mismatch clears the run at once. In automatic mode the bench sends idle ones between the two codes. It also enters automatic mode while a loop-up code is already held, moves the test code to the blocking value, and raises local analog loopback. These cases separate latching from following, and a fresh persistence run from a stale one.

// File: rtl/lcd_pkg.sv
package lcd_pkg;
   typedef enum logic [1:0] {
      LCD_OFF  = 2'b00,
      LCD_UP   = 2'b01,
      LCD_DN   = 2'b10,
      LCD_AUTO = 2'b11
   } lcd_mode_e;

   function automatic int unsigned lcd_cnt_width(input int unsigned persist);
      return $clog2(persist + 2);
   endfunction
endpackage

// File: rtl/lcd_code_watch.sv
module lcd_code_watch #(
   parameter int unsigned LEN     = 5,
   parameter logic [LEN-1:0] CODE = 5'b00001,
   parameter int unsigned PERSIST = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_en,
   input  logic rx_bit,
   input  logic restart,
   output logic sustained
);
   localparam int unsigned CW = lcd_pkg::lcd_cnt_width(PERSIST);
   localparam logic [CW-1:0] SAT = CW'(PERSIST + 1);

   logic [LEN-1:0] win_q;
   logic [LEN-1:0] win_n;
   logic [LEN-1:0] rot_hit;
   logic           hit;
   logic [CW-1:0]  run_q;

   assign win_n = {win_q[LEN-2:0], rx_bit};

   for (genvar r = 0; r < LEN; r++) begin : g_rot
      localparam logic [LEN-1:0] ROT = LEN'((CODE << r) | (CODE >> (LEN - r)));
      assign rot_hit[r] = (win_n == ROT);
   end

   assign hit = |rot_hit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         win_q <= '1;
         run_q <= '0;
      end else begin
         if (bit_en) win_q <= win_n;
         if (restart)     run_q <= '0;
         else if (bit_en) run_q <= hit ? ((run_q == SAT) ? SAT : run_q + 1'b1) : '0;
      end
   end

   assign sustained = (run_q == SAT);

   // R4: a rejected bit empties the run
   a_r4_miss_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_en && !restart && !hit) |=> (run_q == '0));
   // R4: a hold only begins on an accepted matching bit
   a_r4_rise_on_bit: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sustained) |-> $past(bit_en && hit && !restart));
   // R6: restart leaves no hold behind
   a_r6_restart_drops: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> !sustained);
endmodule

// File: rtl/lcd_mode_ctrl.sv
module lcd_mode_ctrl
   import lcd_pkg::*;
#(
   parameter logic [2:0] TEST_LOCK = 3'b110
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] mode,
   input  logic [2:0] tx_test,
   input  logic       local_analog_lb,
   input  logic       up_sus,
   input  logic       dn_sus,
   output logic       restart,
   output logic       status,
   output logic       status_nxt,
   output logic       rlb_en
);
   lcd_mode_e  mode_e;
   logic [1:0] mode_q;
   logic       auto_ok;
   logic       auto_q;
   logic       looped_nxt;

   assign mode_e  = lcd_mode_e'(mode);
   assign auto_ok = (mode_e == LCD_AUTO) && (tx_test != TEST_LOCK);
   assign restart = (mode != mode_q) || (auto_ok != auto_q);

   always_comb begin
      looped_nxt = 1'b0;
      status_nxt = 1'b0;
      if (auto_ok) begin
         if (restart)      looped_nxt = 1'b0;
         else if (!rlb_en) looped_nxt = up_sus && !local_analog_lb;
         else              looped_nxt = !dn_sus;
         status_nxt = looped_nxt;
      end else if (!restart) begin
         unique case (mode_e)
            LCD_UP:  status_nxt = up_sus;
            LCD_DN:  status_nxt = dn_sus;
            default: status_nxt = 1'b0;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= LCD_OFF;
         auto_q <= 1'b0;
         status <= 1'b0;
         rlb_en <= 1'b0;
      end else begin
         mode_q <= mode;
         auto_q <= auto_ok;
         status <= status_nxt;
         rlb_en <= looped_nxt;
      end
   end

   // R1: mode off forces a clear status
   a_r1_off_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_e == LCD_OFF) |=> !status);
   // R7: loopback is always reported on the status bit
   a_r7_lb_shows: assert property (@(posedge clk) disable iff (!rst_n)
      rlb_en |-> status);
   // R6: entry clears status
   a_r6_entry_clear: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> !status);
   // R8: held loop-down releases loopback
   a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
      (rlb_en && dn_sus) |=> !rlb_en);
   // R9 and R10: loopback needs an allowed automatic mode
   a_r9_needs_auto: assert property (@(posedge clk) disable iff (!rst_n)
      !auto_ok |=> !rlb_en);
   // R11: no new loopback under local analog loopback
   a_r11_analog_block: assert property (@(posedge clk) disable iff (!rst_n)
      (!rlb_en && local_analog_lb) |=> !rlb_en);
endmodule

// File: rtl/lcd_irq_pulse.sv
module lcd_irq_pulse (
   input  logic clk,
   input  logic rst_n,
   input  logic irq_en,
   input  logic status,
   input  logic status_nxt,
   output logic irq
);
   always_ff @(posedge clk) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= irq_en && (status_nxt != status);
   end

   // R5: a pulse marks a status edge
   a_r5_irq_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (status != $past(status)));
   // R5: masked edges raise nothing
   a_r5_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en |=> !irq);
endmodule

// File: rtl/loop_code_detector.sv
module loop_code_detector #(
   parameter int unsigned PERSIST_BITS = 7_720_000,
   parameter int unsigned UP_LEN       = 5,
   parameter logic [UP_LEN-1:0] UP_CODE = 5'b00001,
   parameter int unsigned DN_LEN       = 3,
   parameter logic [DN_LEN-1:0] DN_CODE = 3'b001,
   parameter logic [2:0] TEST_LOCK     = 3'b110
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bit_en,
   input  logic       rx_bit,
   input  logic [1:0] mode,
   input  logic [2:0] tx_test,
   input  logic       local_analog_lb,
   input  logic       irq_en,
   output logic       code_status,
   output logic       remote_lb_en,
   output logic       irq
);
   if (PERSIST_BITS < 1) begin : g_chk_persist
      $error("PERSIST_BITS must be at least 1");
   end
   if (UP_LEN < 2 || DN_LEN < 2) begin : g_chk_len
      $error("code lengths must be at least 2");
   end
   if (UP_CODE == '1 || DN_CODE == '1 || UP_CODE == '0 || DN_CODE == '0) begin : g_chk_code
      $error("codes must hold both ones and zeros");
   end

   logic restart;
   logic up_sus;
   logic dn_sus;
   logic status_nxt;

   lcd_code_watch #(.LEN(UP_LEN), .CODE(UP_CODE), .PERSIST(PERSIST_BITS)) u_up_watch (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
      .restart(restart), .sustained(up_sus));

   lcd_code_watch #(.LEN(DN_LEN), .CODE(DN_CODE), .PERSIST(PERSIST_BITS)) u_dn_watch (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
      .restart(restart), .sustained(dn_sus));

   lcd_mode_ctrl #(.TEST_LOCK(TEST_LOCK)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .mode(mode), .tx_test(tx_test),
      .local_analog_lb(local_analog_lb), .up_sus(up_sus), .dn_sus(dn_sus),
      .restart(restart), .status(code_status), .status_nxt(status_nxt),
      .rlb_en(remote_lb_en));

   lcd_irq_pulse u_irq (
      .clk(clk), .rst_n(rst_n), .irq_en(irq_en), .status(code_status),
      .status_nxt(status_nxt), .irq(irq));
endmodule

// File: tb/loop_code_detector_bench.sv
`timescale 1ns/1ps
module loop_code_detector_bench;
   localparam int P = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bit_en = 1'b0, rx_bit = 1'b1;
   logic [1:0] mode = 2'b00;
   logic [2:0] tx_test = 3'b000;
   logic ana = 1'b0, irq_en = 1'b1;
   logic status, rlb, irq;

   int checks = 0, errors = 0, irq_cnt = 0;
   int up_ph = 0, dn_ph = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   loop_code_detector #(.PERSIST_BITS(P)) u_loop_code_detector (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit), .mode(mode),
      .tx_test(tx_test), .local_analog_lb(ana), .irq_en(irq_en),
      .code_status(status), .remote_lb_en(rlb), .irq(irq));

   always @(posedge clk) if (rst_n && irq) irq_cnt++;

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_bit(input logic b);
      @(negedge clk); rx_bit = b; bit_en = 1'b1;
      @(negedge clk); bit_en = 1'b0;
      @(negedge clk);
   endtask

   task automatic flush();
      for (int i = 0; i < 8; i++) send_bit(1'b1);
      up_ph = 0; dn_ph = 0;
   endtask

   task automatic send_up(input int n);
      for (int i = 0; i < n; i++) begin
         send_bit(up_ph == 4);
         up_ph = (up_ph + 1) % 5;
      end
   endtask

   task automatic send_dn(input int n);
      for (int i = 0; i < n; i++) begin
         send_bit(dn_ph == 2);
         dn_ph = (dn_ph + 1) % 3;
      end
   endtask

   task automatic set_mode(input logic [1:0] m);
      @(negedge clk); mode = m;
      idle(2);
   endtask

   task automatic t_reset_off();
      chk("R1 reset status", status, 0);
      chk("R1 reset loopback", rlb, 0);
      set_mode(2'b00);
      flush(); send_up(P + 10);
      chk("R1 off ignores loop-up", status, 0);
      chk("R1 off no loopback", rlb, 0);
   endtask

   task automatic t_manual_up();
      int i0;
      set_mode(2'b01);
      i0 = irq_cnt;
      flush(); send_up(P + 3);
      chk("R4 up one short of threshold", status, 0);
      send_up(1);
      chk("R2 up held sets status", status, 1);
      idle(2);
      chk("R5 rising irq", irq_cnt - i0, 1);
      send_bit(1'b1);
      chk("R2 broken bit clears status", status, 0);
      idle(2);
      chk("R5 falling irq", irq_cnt - i0, 2);
   endtask

   task automatic t_manual_dn();
      int i0;
      set_mode(2'b10);
      flush(); send_up(P + 10);
      chk("R3 down mode ignores loop-up", status, 0);
      @(negedge clk); irq_en = 1'b0;
      i0 = irq_cnt;
      flush(); send_dn(P + 1);
      chk("R4 down one short of threshold", status, 0);
      send_dn(1);
      chk("R3 down held sets status", status, 1);
      idle(2);
      chk("R5 masked irq", irq_cnt - i0, 0);
      @(negedge clk); irq_en = 1'b1;
   endtask

   task automatic t_auto();
      int i0;
      set_mode(2'b00);
      set_mode(2'b11);
      i0 = irq_cnt;
      flush(); send_up(P + 4);
      chk("R7 loop-up sets loopback", rlb, 1);
      chk("R7 loop-up sets status", status, 1);
      flush(); flush();
      chk("R7 loopback holds after code stops", rlb, 1);
      chk("R7 status holds after code stops", status, 1);
      send_dn(P + 1);
      chk("R8 down one short keeps loopback", rlb, 1);
      send_dn(1);
      chk("R8 loop-down clears loopback", rlb, 0);
      chk("R8 loop-down clears status", status, 0);
      idle(2);
      chk("R5 auto irq count", irq_cnt - i0, 2);
   endtask

   task automatic t_entry_exit();
      set_mode(2'b01);
      flush(); send_up(P + 4);
      chk("R2 manual up before entry", status, 1);
      set_mode(2'b11);
      chk("R6 entry clears status", status, 0);
      send_up(P);
      chk("R6 stale run not reused", rlb, 0);
      send_up(1);
      chk("R6 fresh run sets loopback", rlb, 1);
      set_mode(2'b01);
      chk("R9 leaving auto clears loopback", rlb, 0);
   endtask

   task automatic t_blocks();
      set_mode(2'b00);
      @(negedge clk); tx_test = 3'b110;
      set_mode(2'b11);
      flush(); send_up(P + 10);
      chk("R10 test code blocks loopback", rlb, 0);
      chk("R10 test code blocks status", status, 0);
      @(negedge clk); tx_test = 3'b000;
      set_mode(2'b00);
      @(negedge clk); ana = 1'b1;
      set_mode(2'b11);
      flush(); send_up(P + 10);
      chk("R11 analog loopback blocks request", rlb, 0);
      @(negedge clk); ana = 1'b0;
      set_mode(2'b00);
   endtask

   initial begin
      idle(4);
      @(negedge clk); rst_n = 1'b1;
      idle(2);
      t_reset_off();
      t_manual_up();
      t_manual_dn();
      t_auto();
      t_entry_exit();
      t_blocks();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
         $finish;
      end
   end
endmodule